// File: doc/BRIEF.md
# Multiplexed Digit Scanner with PWM Intensity

This block time-multiplexes up to four common-cathode seven-segment digits over one shared set of eight segment lines. A slot counter visits the digits in ascending order, one at a time. Each slot lasts 32 clock cycles, and a 5-bit phase counter inside the slot sets both the brightness, through pulse-width modulation, and a blank cycle at every digit change that stops ghosting between neighbouring digits.

For each digit, the segment pattern comes either straight from that digit's 8-bit register or from a font lookup on its low nibble. The lookup uses either a numeric font with a few letters or the full hexadecimal font. A shutdown input blanks the display. A blank input from a separate blink controller turns the segments off but leaves the scan running. A display-test input lights everything and takes priority over shutdown, blank and the scan limit. No input changes any stored register content. The serial interface, blink timing and analog current setting sit outside this block.

Top module: `digit_scanner`

## Requirements
- R1: With scan limit n (0 to 3), digits 0 through n are selected in ascending order, each for 32 consecutive cycles. A digit above n is never selected unless display test is on.
- R2: One full scan takes 32*(n+1) cycles, so each digit is refreshed more often when fewer digits are scanned.
- R3: `digitN` is active low and at most one bit is low at any time. Segments are lit only while a digit is selected. The first cycle of every digit slot has all segments off.
- R4: With intensity k (0 to 15), a lit digit shows its segments for exactly 2k+1 of the 32 cycles of its slot.
- R5: With decode-enable bit i clear, digit i's register drives the segments directly: `segOut[7]`=DP, `[6]`=A, `[5]`=B, `[4]`=C, `[3]`=D, `[2]`=E, `[1]`=F, `[0]`=G.
- R6: With `hexSel`=0, decoded codes 0x0 to 0xF give glyphs {A..G} 7E,30,6D,79,33,5B,5F,70,7F,7B, then 01 (dash), 4F (E), 37 (H), 0E (L), 67 (P), 00 (blank).
- R7: With `hexSel`=1, decoded codes 0x0 to 0x9 give the same glyphs as R6, and 0xA to 0xF give 77,1F,4E,3D,4F,47 (A, b, C, d, E, F).
- R8: When decoding, register bits 6:4 are ignored and bit 7 drives DP directly. Decode enable is chosen per digit, with bit i controlling digit i.
- R9: With `shutdown`=1 and display test off, all `digitN` bits are high and all segments are off. Stored contents reappear unchanged when shutdown clears.
- R10: With display test on, every digit 0 to 3 is scanned whatever the scan limit. All eight segments are lit for 30 of 32 cycles per slot (15/16), regardless of shutdown and blank.
- R11: With `blank`=1 and display test off, the segments stay off while the digit selects keep scanning with unchanged timing.
- R12: During reset `digitN` is all ones and `segOut` is zero. In the first cycle after reset, digit 0 is selected with its segments off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, one PWM phase per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| digitRegs | input | 32 | Digit registers, digit i in bits 8i+7:8i |
| decodeEn | input | 4 | Per-digit font decode enable |
| intensity | input | 4 | Brightness step k, on-time 2k+1 of 32 |
| scanLimit | input | 2 | Highest digit index scanned |
| shutdown | input | 1 | 1 blanks the display |
| dispTest | input | 1 | 1 lights all segments of all digits |
| hexSel | input | 1 | 0 numeric/letter font, 1 hexadecimal font |
| blank | input | 1 | 1 forces segments off, scan continues |
| digitN | output | 4 | Active-low digit selects |
| segOut | output | 8 | Active-high segments {DP,A,B,C,D,E,F,G} |

## Verification
The outputs are registered one clock after the slot and phase counters. An input change is therefore visible at the next rising edge, while the duty and ordering results only settle once a full scan has passed. After every change of configuration the bench waits longer than the longest scan, 128 cycles plus one. It then counts selections, lit cycles and pattern mismatches per digit over whole scans, sampling on falling edges, so the checks do not depend on the phase at which the window starts. The reset and first-slot checks are exact to the cycle: the first falling edge after release must show digit 0 selected and dark, and the next must show it lit.

// File: rtl/dscan_pkg.sv
`timescale 1ns/1ps
package dscan_pkg;
  localparam int MAX_DIGITS = 4;
  localparam int SLOT_W     = $clog2(MAX_DIGITS);
  localparam int PHASE_W    = 5;
  localparam int INT_W      = 4;
  localparam int SEG_W      = 8;
  localparam int GLYPH_W    = SEG_W - 1;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic              digitGate;
    logic              segGate;
  } strobe_t;

  // glyph bits ordered {A,B,C,D,E,F,G}
  function automatic logic [GLYPH_W-1:0] fontNumeric(input logic [3:0] code);
    case (code)
      4'h0: return 7'h7E;  4'h1: return 7'h30;  4'h2: return 7'h6D;  4'h3: return 7'h79;
      4'h4: return 7'h33;  4'h5: return 7'h5B;  4'h6: return 7'h5F;  4'h7: return 7'h70;
      4'h8: return 7'h7F;  4'h9: return 7'h7B;  4'hA: return 7'h01;  4'hB: return 7'h4F;
      4'hC: return 7'h37;  4'hD: return 7'h0E;  4'hE: return 7'h67;  default: return 7'h00;
    endcase
  endfunction

  function automatic logic [GLYPH_W-1:0] fontHex(input logic [3:0] code);
    case (code)
      4'hA: return 7'h77;  4'hB: return 7'h1F;  4'hC: return 7'h4E;
      4'hD: return 7'h3D;  4'hE: return 7'h4F;  4'hF: return 7'h47;
      default: return fontNumeric(code);
    endcase
  endfunction
endpackage

// File: rtl/dscan_ctrl.sv
`timescale 1ns/1ps
module dscan_ctrl #(
  parameter int DIGITS  = dscan_pkg::MAX_DIGITS,
  parameter int PHASE_W = dscan_pkg::PHASE_W,
  parameter int INT_W   = dscan_pkg::INT_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [INT_W-1:0]            intensity,
  input  logic [dscan_pkg::SLOT_W-1:0] scanLimit,
  input  logic                        dispTest,
  output dscan_pkg::strobe_t          strobe
);
  localparam int SW      = dscan_pkg::SLOT_W;
  localparam int PHASES  = 1 << PHASE_W;
  localparam int TEST_ON = PHASES - PHASES / 16;
  localparam logic [SW-1:0] LAST_SLOT = SW'(DIGITS - 1);

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] onTime;
  logic [SW-1:0]      slot;
  logic [SW-1:0]      effLimit;

  always_comb begin
    effLimit = dispTest ? LAST_SLOT : scanLimit;
    onTime   = dispTest ? PHASE_W'(TEST_ON) : {intensity, 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      slot  <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (phase == '1)
        slot <= (slot >= effLimit) ? '0 : slot + 1'b1;
    end
  end

  // phase 0 of each slot stays dark: inter-digit blanking
  always_comb begin
    strobe.slot      = slot;
    strobe.digitGate = (slot <= effLimit);
    strobe.segGate   = (phase != '0) && (phase <= onTime);
  end
endmodule

// File: rtl/dscan_path.sv
`timescale 1ns/1ps
module dscan_path #(
  parameter int DIGITS = dscan_pkg::MAX_DIGITS,
  parameter int SEG_W  = dscan_pkg::SEG_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dscan_pkg::strobe_t       strobe,
  input  logic [DIGITS*SEG_W-1:0]  digitRegs,
  input  logic [DIGITS-1:0]        decodeEn,
  input  logic                     hexSel,
  input  logic                     shutdown,
  input  logic                     dispTest,
  input  logic                     blank,
  output logic [DIGITS-1:0]        digitN,
  output logic [SEG_W-1:0]         segOut
);
  logic [SEG_W-1:0] pat [DIGITS];
  logic [SEG_W-1:0] curPat;
  logic             selOn;
  logic             litOn;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [SEG_W-1:0]   raw;
    logic [SEG_W-2:0]   glyph;
    assign raw    = digitRegs[d*SEG_W +: SEG_W];
    assign glyph  = hexSel ? dscan_pkg::fontHex(raw[3:0]) : dscan_pkg::fontNumeric(raw[3:0]);
    assign pat[d] = decodeEn[d] ? {raw[SEG_W-1], glyph} : raw;
  end

  always_comb begin
    curPat = pat[strobe.slot];
    selOn  = (dispTest || !shutdown) && strobe.digitGate;
    litOn  = selOn && strobe.segGate && (dispTest || !blank);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      digitN <= '1;
      segOut <= '0;
    end else begin
      digitN <= selOn ? ~(DIGITS'(1) << strobe.slot) : '1;
      segOut <= litOn ? (dispTest ? '1 : curPat) : '0;
    end
  end
endmodule

// File: rtl/digit_scanner.sv
`timescale 1ns/1ps
module digit_scanner #(
  parameter int DIGITS  = dscan_pkg::MAX_DIGITS,
  parameter int SEG_W   = dscan_pkg::SEG_W,
  parameter int INT_W   = dscan_pkg::INT_W,
  parameter int PHASE_W = dscan_pkg::PHASE_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [DIGITS*SEG_W-1:0]     digitRegs,
  input  logic [DIGITS-1:0]           decodeEn,
  input  logic [INT_W-1:0]            intensity,
  input  logic [dscan_pkg::SLOT_W-1:0] scanLimit,
  input  logic                        shutdown,
  input  logic                        dispTest,
  input  logic                        hexSel,
  input  logic                        blank,
  output logic [DIGITS-1:0]           digitN,
  output logic [SEG_W-1:0]            segOut
);
  dscan_pkg::strobe_t strobe;

  dscan_ctrl #(.DIGITS(DIGITS), .PHASE_W(PHASE_W), .INT_W(INT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .intensity(intensity), .scanLimit(scanLimit),
    .dispTest(dispTest), .strobe(strobe)
  );

  dscan_path #(.DIGITS(DIGITS), .SEG_W(SEG_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .digitRegs(digitRegs),
    .decodeEn(decodeEn), .hexSel(hexSel), .shutdown(shutdown),
    .dispTest(dispTest), .blank(blank), .digitN(digitN), .segOut(segOut)
  );
endmodule

// File: rtl/digit_scanner_chk.sv
`timescale 1ns/1ps
module digit_scanner_chk #(
  parameter int DIGITS = 4,
  parameter int SEG_W  = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [dscan_pkg::SLOT_W-1:0] scanLimit,
  input logic                        shutdown,
  input logic                        dispTest,
  input logic                        blank,
  input logic [DIGITS-1:0]           digitN,
  input logic [SEG_W-1:0]            segOut
);
  logic [DIGITS-1:0] allowMask;
  always_comb
    for (int i = 0; i < DIGITS; i++) allowMask[i] = (i <= int'(scanLimit));

  // R1: no digit above the limit is driven outside display test
  a_r1_within_limit: assert property (@(posedge clk) disable iff (!rstN)
    !$past(dispTest) |-> ((~digitN & ~$past(allowMask)) == '0));

  // R3: selects are one-hot-or-none
  a_r3_one_digit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~digitN));

  // R3: segments lit only with a digit selected
  a_r3_no_ghost: assert property (@(posedge clk) disable iff (!rstN)
    (segOut != '0) |-> (digitN != '1));

  // R9: shutdown blanks everything
  a_r9_shutdown_dark: assert property (@(posedge clk) disable iff (!rstN)
    ($past(shutdown) && !$past(dispTest)) |-> (digitN == '1 && segOut == '0));

  // R10: display test shows all-on or all-off only
  a_r10_test_full: assert property (@(posedge clk) disable iff (!rstN)
    $past(dispTest) |-> (segOut == '0 || segOut == '1));

  // R11: blank keeps segments off
  a_r11_blank_dark: assert property (@(posedge clk) disable iff (!rstN)
    ($past(blank) && !$past(dispTest)) |-> (segOut == '0));
endmodule

bind digit_scanner digit_scanner_chk #(.DIGITS(DIGITS), .SEG_W(SEG_W)) uChk (
  .clk(clk), .rstN(rstN), .scanLimit(scanLimit), .shutdown(shutdown),
  .dispTest(dispTest), .blank(blank), .digitN(digitN), .segOut(segOut)
);

// File: tb/digit_scanner_test.sv
`timescale 1ns/1ps
module digit_scanner_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] digitRegs = 32'h0;
  logic [3:0]  decodeEn = 4'h0;
  logic [3:0]  intensity = 4'hF;
  logic [1:0]  scanLimit = 2'd3;
  logic        shutdown = 1'b0, dispTest = 1'b0, hexSel = 1'b0, blank = 1'b0;
  logic [3:0]  digitN;
  logic [7:0]  segOut;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  digit_scanner uut (.clk(clk), .rstN(rstN), .digitRegs(digitRegs), .decodeEn(decodeEn),
    .intensity(intensity), .scanLimit(scanLimit), .shutdown(shutdown), .dispTest(dispTest),
    .hexSel(hexSel), .blank(blank), .digitN(digitN), .segOut(segOut));

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  function automatic logic [6:0] glyph(input logic hex, input logic [3:0] c);
    logic [6:0] t [16] = '{7'h7E,7'h30,7'h6D,7'h79,7'h33,7'h5B,7'h5F,7'h70,
                           7'h7F,7'h7B,7'h01,7'h4F,7'h37,7'h0E,7'h67,7'h00};
    logic [6:0] h [6]  = '{7'h77,7'h1F,7'h4E,7'h3D,7'h4F,7'h47};
    if (hex && c >= 4'hA) return h[c - 4'hA];
    return t[c];
  endfunction

  function automatic logic [7:0] expPat(input int d);
    logic [7:0] r = digitRegs[d*8 +: 8];
    if (dispTest) return 8'hFF;
    if (decodeEn[d]) return {r[7], glyph(hexSel, r[3:0])};
    return r;
  endfunction

  task automatic measure(input string req, input int frames);
    int eff = dispTest ? 3 : int'(scanLimit);
    int len = 32 * (eff + 1) * frames;
    int sel [4] = '{0,0,0,0};
    int on  [4] = '{0,0,0,0};
    int bad [4] = '{0,0,0,0};
    logic [7:0] badVal [4];
    repeat (140) @(negedge clk);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      for (int d = 0; d < 4; d++) if (!digitN[d]) begin
        sel[d]++;
        if (segOut != 8'h0) begin
          on[d]++;
          if (segOut != expPat(d)) begin bad[d]++; badVal[d] = segOut; end
        end
      end
    end
    for (int d = 0; d < 4; d++) begin
      bit act = (!shutdown || dispTest) && d <= eff;
      int onT = dispTest ? 30 : 2 * int'(intensity) + 1;
      int expOn = (act && (dispTest || !blank) && expPat(d) != 8'h0) ? onT * frames : 0;
      check(req, $sformatf("digit%0d select cycles", d), sel[d], act ? 32 * frames : 0);
      check(req, $sformatf("digit%0d lit cycles", d), on[d], expOn);
      check(req, $sformatf("digit%0d pattern", d), bad[d] == 0 ? int'(expPat(d)) : int'(badVal[d]), int'(expPat(d)));
    end
  endtask

  task automatic frameLen(input string req);
    int starts = 0, t0 = 0, t = 0;
    logic prevLit = 1'b1;
    repeat (140) @(negedge clk);
    while (starts < 2 && t < 400) begin
      @(negedge clk); t++;
      if (!digitN[0] && segOut != 8'h0 && !prevLit) begin
        if (starts == 0) t0 = t;
        starts++;
        if (starts == 2) check(req, "scan period", t - t0, 32 * (int'(scanLimit) + 1));
      end
      prevLit = !digitN[0] && segOut != 8'h0;
    end
    if (starts < 2) check(req, "scan period seen", 0, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int seedInit;
    seedInit = $urandom(32'd4242);
    digitRegs = 32'h8149_2A7F;
    repeat (4) @(negedge clk);
    // R12: reset state
    check("R12", "digitN in reset", int'(digitN), 4'hF);
    check("R12", "segOut in reset", int'(segOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R12", "first slot digit", int'(digitN), 4'hE);
    check("R3", "slot start dark", int'(segOut), 0);
    @(negedge clk);
    check("R4", "digit0 lit at phase1", int'(segOut), int'(expPat(0)));

    measure("R5", 2);
    scanLimit = 2'd1; measure("R1", 2);
    for (int n = 0; n < 4; n++) begin scanLimit = 2'(n); frameLen("R2"); end
    intensity = 4'd0; measure("R4", 2);
    intensity = 4'd7; measure("R4", 1);
    intensity = 4'd15;
    // fonts, all 16 codes with random bits 7:4
    for (int f = 0; f < 2; f++) begin
      hexSel = 1'(f); decodeEn = 4'hF;
      for (int g = 0; g < 4; g++) begin
        for (int d = 0; d < 4; d++)
          digitRegs[d*8 +: 8] = {4'($urandom), 4'(4*g + d)};
        measure(f == 0 ? "R6" : "R7", 1);
      end
    end
    decodeEn = 4'b0101; hexSel = 1'b1; digitRegs = 32'hF3_75_8C_0B;
    measure("R8", 1);
    decodeEn = 4'h0; digitRegs = 32'h01_80_55_AA;
    shutdown = 1'b1; measure("R9", 1);
    shutdown = 1'b0; measure("R9", 1);
    blank = 1'b1; measure("R11", 1);
    scanLimit = 2'd0; shutdown = 1'b1; dispTest = 1'b1;
    measure("R10", 2);
    dispTest = 1'b0; shutdown = 1'b0; blank = 1'b0;
    for (int i = 0; i < 8; i++) begin
      digitRegs = $urandom; decodeEn = 4'($urandom); intensity = 4'($urandom);
      scanLimit = 2'($urandom); hexSel = 1'($urandom);
      measure("R1", 1);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule